// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block produces the end-of-byte bus activity of an I2C master. After a received byte it drives the acknowledge bit and clocks it out on SCL. At the end of a transfer it produces the Stop condition. Both lines are open-drain. The block drives them through active-high drive-low enables and reads the actual line levels back through a synchroniser `SYNC_STAGES` deep. A slave that holds SCL low delays the sequence instead of being overridden.

Every timed phase is one baud period long, which is `brg_reload + 1` system clocks. A single reloadable down-counter provides the period, and it runs only while a timed phase is pending. Each phase change waits on the synchronised line level and not on a fixed count. Software starts a sequence by pulsing `ack_req` or `stop_req`. It sees progress on `ack_busy` and `stop_busy`, and at the end it sees a sticky interrupt flag and a stop-detected flag. A transmit-buffer write made while a sequence runs is refused, and the refusal is recorded in a collision flag. `brg_reload` must be at least `SYNC_STAGES`.

In the timing figures below, R is `brg_reload`, S is `SYNC_STAGES`, and all counts are clock edges from the edge that accepts the request.

Top module: `i2c_ack_stop_seq`

## Requirements
- R1: An accepted acknowledge request sets `ack_busy` and drives SCL low at once. It drives SDA low when the latched `ack_data` is 0 (ACK) and leaves SDA released when it is 1 (NACK). SCL is released R+1 edges after acceptance.
- R2: With no stretching, SCL stays high for R+S+2 cycles in an acknowledge sequence, and `ack_busy` clears 2R+S+3 edges after acceptance.
- R3: If a slave holds SCL low for X extra cycles after the master releases it, the release-to-high time and the whole acknowledge sequence each grow by exactly X cycles. The high time does not change.
- R4: On the edge that ends an acknowledge sequence, `ack_busy` clears and `irq_flag` sets. When no stop is pending, SCL then stays driven low until the next sequence is accepted.
- R5: An accepted stop request sets `stop_busy` and drives both SDA and SCL low. SCL is released R+S+2 edges after acceptance.
- R6: SDA is released 2R+2S+4 edges after stop acceptance, and only while SCL is high.
- R7: `stop_seen` sets 2R+3S+5 edges after stop acceptance, when both synchronised lines read high. `stop_busy` clears and `irq_flag` sets at 3R+3S+6 edges, and both lines are then released.
- R8: A `buf_wr` while `ack_busy` or `stop_busy` is high sets `wcol_flag` and leaves `tx_buf` unchanged. A write while idle loads `tx_buf`. `wcol_flag` clears only on `wcol_clr`.
- R9: If both requests arrive together in idle, both busy bits set and the acknowledge sequence runs first. The stop sequence starts on the edge where the acknowledge sequence ends. A request that arrives while either busy bit is high is ignored.
- R10: `irq_flag` stays set until `irq_clr`, and a set in the same cycle wins over the clear. `stop_seen` clears on the edge that accepts a new request.
- R11: After reset both drive enables, both busy bits, all flags and `tx_buf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brg_reload | input | BRG_W | Baud counter reload; one period is reload+1 clocks |
| ack_req | input | 1 | Start an acknowledge sequence (one-cycle pulse) |
| ack_data | input | 1 | Bit to acknowledge with: 0 ACK, 1 NACK |
| stop_req | input | 1 | Start a Stop sequence (one-cycle pulse) |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Transmit buffer write data |
| irq_clr | input | 1 | Clear strobe for irq_flag |
| wcol_clr | input | 1 | Clear strobe for wcol_flag |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| ack_busy | output | 1 | Acknowledge request in progress |
| stop_busy | output | 1 | Stop request pending or in progress |
| irq_flag | output | 1 | Sticky sequence-complete interrupt |
| stop_seen | output | 1 | Stop condition observed on the bus |
| wcol_flag | output | 1 | Buffer write collided with a sequence |
| tx_buf | output | DATA_W | Transmit buffer contents |

## Verification
The acknowledge figures are measured from the edge where `ack_busy` rises: release after R+1 edges, a high window of R+S+2 cycles, and completion after 2R+S+3 edges. The stop figures are measured from the edge where the stop actually starts: SCL release after R+S+2, SDA release after 2R+2S+4, detection after 2R+3S+5 and completion after 3R+3S+6. In the combined case that start edge is the edge on which the acknowledge sequence ends. For each sequence a driver queues these figures before it pulses the request. A monitor samples on the falling clock edge, takes the difference between edge counts and pops the queue in order. Flag and buffer effects are registered on the edge after a strobe, so they are read at the next falling edge. Stretching is modelled by holding SCL low for a chosen number of cycles after the master releases it.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACK_LOW,
      ST_ACK_REL,
      ST_ACK_HIGH,
      ST_STP_SDA,
      ST_STP_CNT,
      ST_STP_SCL,
      ST_STP_HOLD,
      ST_STP_REL,
      ST_STP_TAIL
   } seq_state_e;

   // states in which the baud counter is allowed to count
   function automatic logic is_timed(seq_state_e s);
      return (s == ST_ACK_LOW)  || (s == ST_ACK_HIGH) ||
             (s == ST_STP_CNT)  || (s == ST_STP_HOLD) ||
             (s == ST_STP_TAIL);
   endfunction

   // states that pull SCL low as part of the sequence itself
   function automatic logic pulls_scl(seq_state_e s);
      return (s == ST_ACK_LOW) || (s == ST_STP_SDA) || (s == ST_STP_CNT);
   endfunction

   // stop states that pull SDA low
   function automatic logic stop_pulls_sda(seq_state_e s);
      return (s == ST_STP_SDA) || (s == ST_STP_CNT) ||
             (s == ST_STP_SCL) || (s == ST_STP_HOLD);
   endfunction

   function automatic logic in_ack(seq_state_e s);
      return (s == ST_ACK_LOW) || (s == ST_ACK_REL) || (s == ST_ACK_HIGH);
   endfunction

endpackage

// File: rtl/i2c_seq_sync.sv
module i2c_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign line_q = line_in;
      end else if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b1;
            else        stage_q <= line_in;
         end
         assign line_q = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_in};
         end
         assign line_q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_seq_brg.sv
module i2c_seq_brg #(
   parameter int BRG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [BRG_W-1:0] reload,
   output logic             expired
);

   logic [BRG_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= reload;
      end else if (run && (count_q != '0)) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign expired = run && (count_q == '0);

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
   import i2c_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ack_req,
   input  logic ack_data,
   input  logic stop_req,
   input  logic scl_s,
   input  logic sda_s,
   input  logic brg_expired,
   output logic brg_load,
   output logic brg_run,
   output logic scl_low,
   output logic sda_low,
   output logic ack_busy,
   output logic stop_busy,
   output logic ack_fin,
   output logic stop_fin,
   output logic stop_det,
   output logic seq_accept
);

   seq_state_e state_q, state_d;
   logic       ack_busy_q, stop_busy_q, ack_bit_q, park_q;
   logic       take_ack, take_stop;

   always_comb begin
      state_d   = state_q;
      brg_load  = 1'b0;
      ack_fin   = 1'b0;
      stop_fin  = 1'b0;
      stop_det  = 1'b0;
      take_ack  = 1'b0;
      take_stop = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (ack_req) begin
               take_ack  = 1'b1;
               take_stop = stop_req;
               brg_load  = 1'b1;
               state_d   = ST_ACK_LOW;
            end else if (stop_req) begin
               take_stop = 1'b1;
               state_d   = ST_STP_SDA;
            end
         end
         ST_ACK_LOW:  if (brg_expired) state_d = ST_ACK_REL;
         ST_ACK_REL: begin
            if (scl_s) begin
               brg_load = 1'b1;
               state_d  = ST_ACK_HIGH;
            end
         end
         ST_ACK_HIGH: begin
            if (brg_expired) begin
               ack_fin = 1'b1;
               state_d = stop_busy_q ? ST_STP_SDA : ST_IDLE;
            end
         end
         ST_STP_SDA: begin
            if (!sda_s) begin
               brg_load = 1'b1;
               state_d  = ST_STP_CNT;
            end
         end
         ST_STP_CNT:  if (brg_expired) state_d = ST_STP_SCL;
         ST_STP_SCL: begin
            if (scl_s) begin
               brg_load = 1'b1;
               state_d  = ST_STP_HOLD;
            end
         end
         ST_STP_HOLD: if (brg_expired) state_d = ST_STP_REL;
         ST_STP_REL: begin
            if (scl_s && sda_s) begin
               stop_det = 1'b1;
               brg_load = 1'b1;
               state_d  = ST_STP_TAIL;
            end
         end
         ST_STP_TAIL: begin
            if (brg_expired) begin
               stop_fin = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ack_busy_q  <= 1'b0;
         stop_busy_q <= 1'b0;
         ack_bit_q   <= 1'b1;
         park_q      <= 1'b0;
      end else begin
         state_q <= state_d;
         if (take_ack) begin
            ack_busy_q <= 1'b1;
            ack_bit_q  <= ack_data;
         end else if (ack_fin) begin
            ack_busy_q <= 1'b0;
         end
         if (take_stop)     stop_busy_q <= 1'b1;
         else if (stop_fin) stop_busy_q <= 1'b0;
         if (take_ack || take_stop)      park_q <= 1'b0;
         else if (ack_fin && !stop_busy_q) park_q <= 1'b1;
      end
   end

   assign brg_run    = is_timed(state_q);
   assign scl_low    = park_q || pulls_scl(state_q);
   assign sda_low    = (in_ack(state_q) && !ack_bit_q) || stop_pulls_sda(state_q);
   assign ack_busy   = ack_busy_q;
   assign stop_busy  = stop_busy_q;
   assign seq_accept = take_ack || take_stop;

endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_done,
   input  logic              stop_det,
   input  logic              seq_accept,
   input  logic              busy,
   input  logic              irq_clr,
   input  logic              wcol_clr,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   output logic              irq_flag,
   output logic              stop_seen,
   output logic              wcol_flag,
   output logic [DATA_W-1:0] tx_buf
);

   logic collide;
   assign collide = buf_wr && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag  <= 1'b0;
         stop_seen <= 1'b0;
         wcol_flag <= 1'b0;
         tx_buf    <= '0;
      end else begin
         if (seq_done)     irq_flag <= 1'b1;
         else if (irq_clr) irq_flag <= 1'b0;

         if (stop_det)        stop_seen <= 1'b1;
         else if (seq_accept) stop_seen <= 1'b0;

         if (collide)       wcol_flag <= 1'b1;
         else if (wcol_clr) wcol_flag <= 1'b0;

         if (buf_wr && !busy) tx_buf <= buf_wdata;
      end
   end

endmodule

// File: rtl/i2c_ack_stop_seq.sv
module i2c_ack_stop_seq #(
   parameter int BRG_W       = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BRG_W-1:0]  brg_reload,
   input  logic              ack_req,
   input  logic              ack_data,
   input  logic              stop_req,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              irq_clr,
   input  logic              wcol_clr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   output logic              ack_busy,
   output logic              stop_busy,
   output logic              irq_flag,
   output logic              stop_seen,
   output logic              wcol_flag,
   output logic [DATA_W-1:0] tx_buf
);

   localparam int MAX_SYNC = 4;

   generate
      if (BRG_W < 2) begin : g_bad_brg_w
         $error("BRG_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if ((SYNC_STAGES < 0) || (SYNC_STAGES > MAX_SYNC)) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   logic scl_s, sda_s;
   logic brg_load, brg_run, brg_expired;
   logic ack_fin, stop_fin, stop_det, seq_accept;

   i2c_seq_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_q(scl_s)
   );

   i2c_seq_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_q(sda_s)
   );

   i2c_seq_brg #(.BRG_W(BRG_W)) u_brg (
      .clk(clk), .rst_n(rst_n), .load(brg_load), .run(brg_run),
      .reload(brg_reload), .expired(brg_expired)
   );

   i2c_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .ack_req(ack_req), .ack_data(ack_data), .stop_req(stop_req),
      .scl_s(scl_s), .sda_s(sda_s), .brg_expired(brg_expired),
      .brg_load(brg_load), .brg_run(brg_run),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low),
      .ack_busy(ack_busy), .stop_busy(stop_busy),
      .ack_fin(ack_fin), .stop_fin(stop_fin), .stop_det(stop_det),
      .seq_accept(seq_accept)
   );

   i2c_seq_status #(.DATA_W(DATA_W)) u_status (
      .clk(clk), .rst_n(rst_n),
      .seq_done(ack_fin || stop_fin), .stop_det(stop_det),
      .seq_accept(seq_accept), .busy(ack_busy || stop_busy),
      .irq_clr(irq_clr), .wcol_clr(wcol_clr),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata),
      .irq_flag(irq_flag), .stop_seen(stop_seen),
      .wcol_flag(wcol_flag), .tx_buf(tx_buf)
   );

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_data,
   input logic              stop_req,
   input logic              buf_wr,
   input logic              irq_clr,
   input logic              ack_busy,
   input logic              stop_busy,
   input logic              scl_drive_low,
   input logic              sda_drive_low,
   input logic              irq_flag,
   input logic              stop_seen,
   input logic              wcol_flag,
   input logic [DATA_W-1:0] tx_buf
);

   // R1: acknowledge start pulls SCL and drives the latched bit on SDA
   assert_ack_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_busy) |-> scl_drive_low && (sda_drive_low == !$past(ack_data)));

   // R4: end of acknowledge raises the interrupt and keeps SCL low
   assert_ack_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_busy) |-> irq_flag && scl_drive_low);

   // R5: a stop that starts from idle pulls both lines
   assert_stop_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stop_busy) && !ack_busy) |-> scl_drive_low && sda_drive_low);

   // R7: stop detection only with both lines released and the stop still busy
   assert_stop_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_seen) |-> !scl_drive_low && !sda_drive_low && stop_busy);

   // R8: a write during a sequence collides and leaves the buffer alone
   assert_wcol_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr && (ack_busy || stop_busy)) |=> wcol_flag && $stable(tx_buf));

   // R9: no acknowledge starts while a stop runs
   assert_no_ack_in_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_busy && !ack_busy) |=> !$rose(ack_busy));

   // R9: a stop requested with an acknowledge is held pending
   assert_stop_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_busy) && $past(stop_req)) |-> stop_busy);

   // R10: interrupt is sticky until cleared
   assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

endmodule

bind i2c_ack_stop_seq i2c_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack_data(ack_data), .stop_req(stop_req),
   .buf_wr(buf_wr), .irq_clr(irq_clr), .ack_busy(ack_busy),
   .stop_busy(stop_busy), .scl_drive_low(scl_drive_low),
   .sda_drive_low(sda_drive_low), .irq_flag(irq_flag),
   .stop_seen(stop_seen), .wcol_flag(wcol_flag), .tx_buf(tx_buf)
);

// File: tb/i2c_ack_stop_seq_tb.sv
module i2c_ack_stop_seq_tb;

   localparam int BRG_W  = 8;
   localparam int DATA_W = 8;
   localparam int SYNC   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [BRG_W-1:0]  brg_reload = 8'd3;
   logic              ack_req = 1'b0, ack_data = 1'b0, stop_req = 1'b0;
   logic              buf_wr = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0;
   logic [DATA_W-1:0] buf_wdata = '0;
   logic              scl_in, sda_in, slave_hold = 1'b0;
   logic              scl_drive_low, sda_drive_low, ack_busy, stop_busy;
   logic              irq_flag, stop_seen, wcol_flag;
   logic [DATA_W-1:0] tx_buf;

   always #2 clk = ~clk;

   assign scl_in = !(scl_drive_low || slave_hold);
   assign sda_in = !sda_drive_low;

   i2c_ack_stop_seq #(.BRG_W(BRG_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload),
      .ack_req(ack_req), .ack_data(ack_data), .stop_req(stop_req),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata), .irq_clr(irq_clr),
      .wcol_clr(wcol_clr), .scl_in(scl_in), .sda_in(sda_in),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .ack_busy(ack_busy), .stop_busy(stop_busy), .irq_flag(irq_flag),
      .stop_seen(stop_seen), .wcol_flag(wcol_flag), .tx_buf(tx_buf)
   );

   int total = 0, bad = 0, cyc = 0;
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      string what;
      string req;
      int    val;
   } item_t;
   item_t exp_q[$];

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push(string what, string req, int val);
      item_t it;
      it.what = what; it.req = req; it.val = val;
      exp_q.push_back(it);
   endtask

   task automatic push_ack(int r, int x, int d);
      push("ack_low_len", "R1", r + 1 + x);
      push("ack_scl_high", "R2", r + SYNC + 2);
      push("ack_sda", "R1", d);
      push("ack_len", (x > 0) ? "R3" : "R2", 2*r + SYNC + 3 + x);
      push("ack_irq", "R4", 1);
   endtask

   task automatic push_stop(int r);
      push("stop_scl_rel", "R5", r + SYNC + 2);
      push("stop_sda_rel", "R6", 2*r + 2*SYNC + 4);
      push("stop_sda_while_scl", "R6", 1);
      push("stop_seen_at", "R7", 2*r + 3*SYNC + 5);
      push("stop_len", "R7", 3*r + 3*SYNC + 6);
   endtask

   function automatic void emit(string what, int act);
      item_t it;
      if (exp_q.size() == 0) begin
         total++; bad++;
         $display("FAIL R2 unexpected %s: actual=%0d expected=none", what, act);
      end else begin
         it = exp_q.pop_front();
         total++;
         if ((it.what != what) || (it.val != act)) begin
            bad++;
            $display("FAIL %s %s: actual=%0d (%s) expected=%0d", it.req, it.what,
                     act, what, it.val);
         end
      end
   endfunction

   // monitor
   bit prev_ack = 0, prev_stp = 0, a_seen_hi = 0, s_scl_seen = 0, s_sda_seen = 0;
   int t_a = 0, a_hi = 0, a_low = 0, a_sda = 0;
   int t_s = 0, s_scl = 0, s_sda = 0, s_seen = 0, s_ok = 0;
   bit prev_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit stp_act = stop_busy && !ack_busy;
         if (ack_busy && !prev_ack) begin
            t_a = cyc; a_hi = 0; a_seen_hi = 0;
         end
         if (ack_busy && scl_in) begin
            a_hi++;
            if (!a_seen_hi) begin
               a_seen_hi = 1; a_low = cyc - t_a; a_sda = sda_in;
            end
         end
         if (!ack_busy && prev_ack) begin
            emit("ack_low_len", a_low);
            emit("ack_scl_high", a_hi);
            emit("ack_sda", a_sda);
            emit("ack_len", cyc - t_a);
            emit("ack_irq", irq_flag);
         end
         if (stp_act && !prev_stp) begin
            t_s = cyc; s_scl_seen = 0; s_sda_seen = 0; s_seen = 0; s_ok = 0;
         end
         if (stp_act) begin
            if (scl_in && !s_scl_seen) begin
               s_scl_seen = 1; s_scl = cyc - t_s;
            end
            if (sda_in && !s_sda_seen && (cyc != t_s)) begin
               s_sda_seen = 1; s_sda = cyc - t_s; s_ok = scl_in;
            end
            if (stop_seen && !prev_seen) s_seen = cyc - t_s;
         end
         if (!stp_act && prev_stp) begin
            emit("stop_scl_rel", s_scl);
            emit("stop_sda_rel", s_sda);
            emit("stop_sda_while_scl", s_ok);
            emit("stop_seen_at", s_seen);
            emit("stop_len", cyc - t_s);
         end
         prev_ack  = ack_busy;
         prev_stp  = stp_act;
         prev_seen = stop_seen;
      end
   end

   // driver helpers
   task automatic req_ack(bit d);
      @(negedge clk); ack_req = 1; ack_data = d;
      @(negedge clk); ack_req = 0;
   endtask

   task automatic req_stop();
      @(negedge clk); stop_req = 1;
      @(negedge clk); stop_req = 0;
   endtask

   task automatic req_both(bit d);
      @(negedge clk); ack_req = 1; stop_req = 1; ack_data = d;
      @(negedge clk); ack_req = 0; stop_req = 0;
   endtask

   task automatic write_buf(logic [DATA_W-1:0] v);
      buf_wr = 1; buf_wdata = v;
      @(negedge clk); buf_wr = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         if (!ack_busy && !stop_busy) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic end_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      end_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "scl_drive_low", scl_drive_low, 0);
      chk("R11", "sda_drive_low", sda_drive_low, 0);
      chk("R11", "busy", {ack_busy, stop_busy}, 0);
      chk("R11", "flags", {irq_flag, stop_seen, wcol_flag}, 0);
      chk("R11", "tx_buf", tx_buf, 0);

      // ACK, reload 3
      brg_reload = 8'd3;
      push_ack(3, 0, 0);
      req_ack(0);
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R4", "scl parked low", scl_drive_low, 1);
      chk("R10", "irq sticky", irq_flag, 1);

      // idle buffer write
      write_buf(8'hA5);
      chk("R8", "idle write tx_buf", tx_buf, 8'hA5);
      chk("R8", "idle write no wcol", wcol_flag, 0);
      irq_clr = 1; @(negedge clk); irq_clr = 0;
      chk("R10", "irq cleared", irq_flag, 0);

      // stop alone, with a collision and an ignored request
      push_stop(3);
      req_stop();
      write_buf(8'h3C);
      chk("R8", "wcol set in stop", wcol_flag, 1);
      chk("R8", "tx_buf kept", tx_buf, 8'hA5);
      ack_req = 1; @(negedge clk); ack_req = 0;
      chk("R9", "ack during stop ignored", ack_busy, 0);
      wait_idle();
      chk("R7", "stop_seen", stop_seen, 1);
      chk("R7", "irq after stop", irq_flag, 1);
      chk("R7", "lines released", {scl_drive_low, sda_drive_low}, 0);
      repeat (5) @(negedge clk);
      chk("R8", "wcol sticky", wcol_flag, 1);
      wcol_clr = 1; @(negedge clk); wcol_clr = 0;
      chk("R8", "wcol cleared", wcol_flag, 0);

      // NACK, reload 6, slave stretches 5 cycles
      brg_reload = 8'd6;
      push_ack(6, 5, 1);
      slave_hold = 1;
      fork
         begin
            wait (scl_drive_low == 1'b1);
            wait (scl_drive_low == 1'b0);
            repeat (6) @(negedge clk);
            slave_hold = 0;
         end
      join_none
      req_ack(1);
      chk("R10", "stop_seen cleared on request", stop_seen, 0);
      write_buf(8'h77);
      chk("R8", "wcol set in ack", wcol_flag, 1);
      chk("R8", "tx_buf kept in ack", tx_buf, 8'hA5);
      wait_idle();
      wcol_clr = 1; @(negedge clk); wcol_clr = 0;

      // both requests together, NACK, reload 2
      brg_reload = 8'd2;
      push_ack(2, 0, 1);
      push_stop(2);
      req_both(1);
      chk("R9", "both busy after joint request", {ack_busy, stop_busy}, 2'b11);
      wait_idle();
      chk("R9", "stop ran after ack", stop_seen, 1);

      repeat (4) @(negedge clk);
      chk("R2", "all sequences observed", exp_q.size(), 0);
      end_run();
   end

endmodule